// File: doc/BRIEF.md
# Serial Bus Interrupt Aggregator

This unit gathers twelve event sources of a serial bus controller into one raw status word, qualifies that word with a software-written enable mask, and drives a single registered interrupt line. Ten of the sources are sticky: a one-cycle pulse from the bus engine sets a latch bit, and the latch stays set until software reads a clear address. The other two sources follow FIFO fill levels. Receive-full compares the receive level with a programmable threshold. Transmit-empty compares the transmit level with a second programmable threshold. Both are recomputed every cycle and cannot be cleared.

Software reaches the unit through a simple register port. Reads return data combinationally in the same cycle. Writes take effect at the clock edge. A read of a clear address returns zero and, at that edge, drops the selected latched sources. There is one clear address for each source and one address that clears every sticky source at once. A pulse that arrives in the same cycle as a clear of its bit is still kept, so no event is lost.

Top module: `sbus_irq_unit`

## Requirements
- R1: Status bit positions are: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A pulse on `evt_pulse[i]` for a sticky source sets raw bit i (read at address 0x00) from the next edge, and the bit holds while no clear reaches it.
- R2: Reading address 0x02 returns the pending word, equal to raw status AND the mask (mask read/write at address 0x01).
- R3: `irq_o` is the OR of the pending bits, registered: it reflects the pending word one clock later. With a mask of zero, `irq_o` is low.
- R4: A read of address 0x05 clears every sticky source at that clock edge, and the read returns zero.
- R5: A read of address 0x10+i clears only sticky source i and returns zero.
- R6: A pulse arriving in the same cycle as a clear read that covers its bit leaves the bit set.
- R7: Raw bit 2 is 1 exactly when `rx_level` is greater than the rx threshold (address 0x04, reset 0, so one entry is enough). Raw bit 4 is 1 exactly when `tx_level` is less than or equal to the tx threshold (address 0x03, reset FIFO_DEPTH/2).
- R8: Level bits 2 and 4 are unaffected by clear reads, and pulses on `evt_pulse[2]` and `evt_pulse[4]` are ignored.
- R9: After reset the mask is zero, no sticky source is set, and `irq_o` is low.
- R10: The mask and both thresholds read back what was written. Writes to the raw, pending and clear addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 12 | One-cycle event pulses from the bus engine, one per source |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of a clear address clears |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of `reg_rd` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with its defaults: FIFO_DEPTH 32, so the levels are 6 bits wide and the tx threshold resets to 16, with 6-bit addresses and 16-bit data. These values put both threshold edges within reach of small level values. Levels of 0 through 4 cover the one-entry receive case and the equality boundary of both comparators. They also make transmit-empty pend from reset, which lets the vector table show a level source leaking into the pending word whenever the mask enables it.

// File: rtl/sbus_irq_pkg.sv
package sbus_irq_pkg;
    localparam int NSRC = 12;

    localparam int B_RX_UNDER = 0;
    localparam int B_RX_OVER  = 1;
    localparam int B_RX_FULL  = 2;
    localparam int B_TX_OVER  = 3;
    localparam int B_TX_EMPTY = 4;
    localparam int B_RD_REQ   = 5;
    localparam int B_TX_ABORT = 6;
    localparam int B_RX_DONE  = 7;
    localparam int B_ACTIVITY = 8;
    localparam int B_STOP     = 9;
    localparam int B_START    = 10;
    localparam int B_GCALL    = 11;

    localparam logic [NSRC-1:0] LEVEL_SRC = NSRC'((1 << B_RX_FULL) | (1 << B_TX_EMPTY));
    localparam logic [NSRC-1:0] STICKY    = ~LEVEL_SRC;

    // register map
    localparam int A_RAW      = 'h00;
    localparam int A_MASK     = 'h01;
    localparam int A_PEND     = 'h02;
    localparam int A_TX_THR   = 'h03;
    localparam int A_RX_THR   = 'h04;
    localparam int A_CLR_ALL  = 'h05;
    localparam int A_CLR_BASE = 'h10;
endpackage

// File: rtl/sbus_irq_level.sv
module sbus_irq_level #(
    parameter int LVL_W = 6
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_thr,
    input  logic [LVL_W-1:0] tx_thr,
    output logic             rx_full_o,
    output logic             tx_empty_o
);
    // Both flags are plain comparisons, recomputed every cycle.
    always_comb begin
        rx_full_o  = (rx_level > rx_thr);
        tx_empty_o = (tx_level <= tx_thr);
    end
endmodule

// File: rtl/sbus_irq_latch.sv
module sbus_irq_latch
    import sbus_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] lat_o
);
    typedef struct packed {
        logic [NSRC-1:0] lat;
    } lat_t;

    lat_t st_d, st_q;

    // A new pulse wins over a clear in the same cycle.
    always_comb begin
        st_d     = st_q;
        st_d.lat = ((st_q.lat & ~clr_i) | evt_i) & STICKY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_o = st_q.lat;

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        if (STICKY[i]) begin : g_sticky
            p_event_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[i] |=> lat_o[i]);
            p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !evt_i[i]) |=> !lat_o[i]);
            p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[i] && !evt_i[i]) |=> $stable(lat_o[i]));
        end else begin : g_level
            p_pulse_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[i] |=> !lat_o[i]);
        end
    end
endmodule

// File: rtl/sbus_irq_regs.sv
module sbus_irq_regs
    import sbus_irq_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int LVL_W      = 6,
    parameter int TX_THR_RST = 16,
    parameter int RX_THR_RST = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NSRC-1:0]   raw_i,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NSRC-1:0]   mask_o,
    output logic [LVL_W-1:0]  tx_thr_o,
    output logic [LVL_W-1:0]  rx_thr_o,
    output logic [NSRC-1:0]   clr_o
);
    typedef struct packed {
        logic [NSRC-1:0]  mask;
        logic [LVL_W-1:0] tx_thr;
        logic [LVL_W-1:0] rx_thr;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit_all;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb hit_all = reg_rd && (reg_addr == ADDR_W'(A_CLR_ALL));

    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        assign clr_o[i] = STICKY[i] &
            (hit_all | (reg_rd && (reg_addr == ADDR_W'(A_CLR_BASE + i))));
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_W'(A_MASK):   st_d.mask   = reg_wdata[NSRC-1:0];
                ADDR_W'(A_TX_THR): st_d.tx_thr = reg_wdata[LVL_W-1:0];
                ADDR_W'(A_RX_THR): st_d.rx_thr = reg_wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask   <= '0;
            st_q.tx_thr <= LVL_W'(TX_THR_RST);
            st_q.rx_thr <= LVL_W'(RX_THR_RST);
        end else begin
            st_q <= st_d;
        end
    end

    // Clear addresses fall to the default and read back as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                ADDR_W'(A_RAW):    reg_rdata = DATA_W'(raw_i);
                ADDR_W'(A_MASK):   reg_rdata = DATA_W'(st_q.mask);
                ADDR_W'(A_PEND):   reg_rdata = DATA_W'(raw_i & st_q.mask);
                ADDR_W'(A_TX_THR): reg_rdata = DATA_W'(st_q.tx_thr);
                ADDR_W'(A_RX_THR): reg_rdata = DATA_W'(st_q.rx_thr);
                default: ;
            endcase
        end
    end

    assign mask_o   = st_q.mask;
    assign tx_thr_o = st_q.tx_thr;
    assign rx_thr_o = st_q.rx_thr;

    p_clear_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> (reg_rdata == '0));
    p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(A_MASK)) |=> (mask_o == $past(reg_wdata[NSRC-1:0])));
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_W'(A_MASK)) |=> $stable(mask_o));
endmodule

// File: rtl/sbus_irq_unit.sv
module sbus_irq_unit
    import sbus_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int TX_THR_RST = FIFO_DEPTH / 2,
    parameter int RX_THR_RST = 0,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_pulse,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    typedef struct packed {
        logic irq;
    } top_t;

    logic [NSRC-1:0]  lat, clr, mask, raw;
    logic [LVL_W-1:0] tx_thr, rx_thr;
    logic             rx_full, tx_empty;
    top_t             st_d, st_q;

    sbus_irq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
        .TX_THR_RST(TX_THR_RST), .RX_THR_RST(RX_THR_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .raw_i(raw),
        .reg_rdata(reg_rdata), .mask_o(mask), .tx_thr_o(tx_thr),
        .rx_thr_o(rx_thr), .clr_o(clr)
    );

    sbus_irq_latch u_latch (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .clr_i(clr), .lat_o(lat)
    );

    sbus_irq_level #(.LVL_W(LVL_W)) u_level (
        .rx_level(rx_level), .tx_level(tx_level), .rx_thr(rx_thr),
        .tx_thr(tx_thr), .rx_full_o(rx_full), .tx_empty_o(tx_empty)
    );

    always_comb begin
        raw             = lat;
        raw[B_RX_FULL]  = rx_full;
        raw[B_TX_EMPTY] = tx_empty;
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(raw & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw & mask)) |=> irq_o);
    p_irq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(raw & mask)) |=> !irq_o);
    p_mask_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq_o);
endmodule

// File: tb/sim_sbus_irq_unit.sv
module sim_sbus_irq_unit;
    import sbus_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_pulse = '0;
    logic [5:0]  rx_level = '0;
    logic [5:0]  tx_level = '0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int d;

    always #10 clk = ~clk;

    sbus_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .rx_level(rx_level),
        .tx_level(tx_level), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    typedef struct packed {
        logic [11:0] evt;
        logic [11:0] msk;
        logic [11:0] raw;
        logic [11:0] pend;
        logic        irq;
    } vec_t;

    // levels 0/0 with reset thresholds: tx empty (bit 4) is always set
    localparam vec_t VECS [6] = '{
        '{12'h001, 12'h001, 12'h011, 12'h001, 1'b1},
        '{12'hFFF, 12'h000, 12'hFFB, 12'h000, 1'b0},
        '{12'h800, 12'h7FF, 12'h810, 12'h010, 1'b1},
        '{12'h014, 12'h004, 12'h010, 12'h000, 1'b0},
        '{12'h140, 12'h0C0, 12'h150, 12'h040, 1'b1},
        '{12'h100, 12'h100, 12'h110, 12'h100, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd_evt(input int a, input logic [11:0] e, output int dat);
        @(negedge clk);
        reg_addr  = 6'(a);
        reg_rd    = 1'b1;
        evt_pulse = e;
        #2 dat = int'(reg_rdata);
        @(posedge clk);
        #1 reg_rd = 1'b0;
        evt_pulse = '0;
    endtask

    task automatic rd(input int a, output int dat);
        rd_evt(a, 12'h000, dat);
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        reg_addr  = 6'(a);
        reg_wdata = 16'(v);
        reg_wr    = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(posedge clk);
        #1 evt_pulse = '0;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9: reset state
        #1 chk("R9 irq after reset", int'(irq_o), 0);
        rd(A_MASK, d);   chk("R9 mask after reset", d, 0);
        rd(A_RAW, d);    chk("R9/R7 raw after reset", d, 'h010);
        rd(A_TX_THR, d); chk("R7 tx threshold reset", d, 16);
        rd(A_RX_THR, d); chk("R7 rx threshold reset", d, 0);

        // vector table: R1 R2 R3 R8
        foreach (VECS[k]) begin
            rd(A_CLR_ALL, d);
            wr(A_MASK, int'(VECS[k].msk));
            pulse(VECS[k].evt);
            rd(A_RAW, d);  chk("R1 raw status", d, int'(VECS[k].raw));
            rd(A_PEND, d); chk("R2 pending word", d, int'(VECS[k].pend));
            chk("R3 irq from pending", int'(irq_o), int'(VECS[k].irq));
        end

        // R3: registered latency, then mask zero silences
        rd(A_CLR_ALL, d);
        wr(A_MASK, 'h001);
        @(posedge clk); #1;
        chk("R3 irq idle", int'(irq_o), 0);
        pulse(12'h001);
        chk("R3 irq one clock late", int'(irq_o), 0);
        @(posedge clk); #1;
        chk("R3 irq raised", int'(irq_o), 1);
        wr(A_MASK, 'h000);
        @(posedge clk); #1;
        chk("R3 mask zero drops irq", int'(irq_o), 0);

        // R4 R5 R8: clear reads
        rd(A_CLR_ALL, d);
        pulse(12'h0C3);
        rd(A_CLR_BASE + 1, d); chk("R5 clear read returns zero", d, 0);
        rd(A_RAW, d);          chk("R5 only bit 1 cleared", d, 'h0D1);
        rd(A_CLR_BASE + 4, d);
        rd(A_RAW, d);          chk("R8 tx empty survives its clear", d, 'h0D1);
        rx_level = 6'd1;
        rd(A_RAW, d);          chk("R7 one rx entry sets rx full", d, 'h0D5);
        rd(A_CLR_ALL, d);      chk("R4 clear-all returns zero", d, 0);
        rd(A_RAW, d);          chk("R4/R8 clear-all keeps level bits", d, 'h014);

        // R7: threshold boundaries
        wr(A_RX_THR, 3);
        rx_level = 6'd3;
        rd(A_RAW, d);          chk("R7 rx level equal to threshold", d, 'h010);
        rx_level = 6'd4;
        rd(A_RAW, d);          chk("R7 rx level above threshold", d, 'h014);
        wr(A_TX_THR, 2);
        tx_level = 6'd3;
        rd(A_RAW, d);          chk("R7 tx level above threshold", d, 'h004);
        tx_level = 6'd2;
        rd(A_RAW, d);          chk("R7 tx level equal to threshold", d, 'h014);
        rd(A_RX_THR, d);       chk("R10 rx threshold readback", d, 3);
        rd(A_TX_THR, d);       chk("R10 tx threshold readback", d, 2);
        rx_level = 6'd0;
        tx_level = 6'd0;

        // R6: pulse coinciding with clear
        rd_evt(A_CLR_ALL, 12'h200, d);
        rd(A_RAW, d);          chk("R6 pulse kept over clear-all", d, 'h210);
        rd_evt(A_CLR_BASE + 9, 12'h200, d);
        rd(A_RAW, d);          chk("R6 pulse kept over own clear", d, 'h210);
        rd_evt(A_CLR_BASE + 9, 12'h001, d);
        rd(A_RAW, d);          chk("R5 bit 9 cleared, other pulse kept", d, 'h011);

        // R10: writes to read-only and clear addresses
        wr(A_RAW, 'hFFF);
        wr(A_CLR_ALL, 'hFFF);
        wr(A_PEND, 'hFFF);
        rd(A_RAW, d);          chk("R10 status writes ignored", d, 'h011);
        rd(A_MASK, d);         chk("R10 mask untouched", d, 0);
        wr(A_MASK, 'hABC);
        rd(A_MASK, d);         chk("R10 mask readback", d, 'hABC);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule